// File: doc/BRIEF.md
# Always-On Wake-Up Timer

This block is a 32-bit counter that keeps counting in its own timer clock domain while the processor's bus clock is stopped. When it reaches its terminal count, it raises a sticky interrupt that can wake the core, and it sends a one-cycle conversion-start pulse. Software programs it through four word registers: a reload value, a read-only counter snapshot, a control word and a write-only interrupt clear. These registers live in the bus clock domain.

The control word sets the count direction, enable, periodic or free-running reload, prescaler division and number format. The format is either plain binary or a packed time of day, with bytes for hours, minutes, seconds and hundredths, and hours wrapping after 23 or after 255. The control word also selects the timer clock source. That choice goes out as a registered code to an external clock multiplexer, which is not part of this block.

Control and load writes cross into the timer domain through a toggle request/acknowledge handshake. The counter value comes back through a continuously refreshed handshake snapshot, so a read never returns a half-updated word. The interrupt clear crosses as a toggle, so the interrupt itself can be raised with no bus clock present.

Top module: `wake_timer`

## Requirements
- R1: After reset, the control register reads 0, the load register reads 0, the value register reads 0xFFFFFFFF and `irq` is low. Addresses are 0 load, 1 value, 2 control and 3 clear.
- R2: Control bits 31:11 read as zero whatever is written to them. Bits 10:0 read back as written.
- R3: `src_sel` reflects control bits 10:9. Codes 00 and 01 give 0 (external crystal), 10 gives 1 (internal oscillator) and 11 gives 2 (core clock).
- R4: In binary format (bits 5:4 = 00), counting down (bit 8 = 0) and free-running (bit 6 = 0), a tick at value 0 wraps the counter to 0xFFFFFFFF. That tick sets `irq` and pulses `conv_start` for one timer cycle.
- R5: In periodic mode (bit 6 = 1), the tick at the terminal value reloads the load register. Counting down from load L, events are therefore (L+1)·D timer cycles apart.
- R6: Prescale bits 3:0 set the division D. Code 0000 gives 1, 0100 gives 16, 1000 gives 256 and 1111 gives 32768. Every other code divides by 1.
- R7: Counting up (bit 8 = 1) in binary format, the terminal value is 0xFFFFFFFF and the counter wraps to 0.
- R8: In time format, the value packs hours in bits 31:24, minutes in 23:16, seconds in 15:8 and hundredths in 7:0. Counting up carries at 99 hundredths, 59 seconds and 59 minutes. The top value is 23:59:59:99 for format 10 and 255:59:59:99 for format 11, and it wraps to zero with an event. Hour 23 rolls on to 24 in format 11 with no event.
- R9: Counting down in time format borrows across the fields in the same way. Zero is the terminal value and wraps to the top value for the selected format.
- R10: With enable (bit 7) low, the counter holds its value. A load-register write copies the new value into the counter whether or not the timer is enabled.
- R11: `irq` stays set until any write to address 3. After such a write it falls.
- R12: The counter runs, and `irq` can be raised, while `bus_clk` is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus register clock (may be gated) |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| tmr_clk | input | 1 | Always-running timer clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after `rd_en` |
| src_sel | output | 2 | Timer clock source code for the external multiplexer |
| irq | output | 1 | Sticky wake interrupt, timer domain |
| conv_start | output | 1 | One-cycle conversion-start pulse, timer domain |

## Verification
The hardest situation to reach from the ports is a multi-field time carry or borrow caught after exactly one tick. The counter lives behind a handshake, and a stop command only takes effect some cycles after it is issued. The bench uses divide-by-256, so a tick is far longer than the crossing delay. It polls the value snapshot until it changes and then disables the timer at once, so exactly one step is observed. A second hard case is the interrupt firing with the bus clock gated. The bench stops `bus_clk` after enabling a short down-count and watches `irq` on timer edges alone. Prescaler periods are measured in the timer domain as the spacing between `conv_start` pulses in periodic mode.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int CNT_W  = 32;
  localparam int CTRL_W = 11;

  typedef enum logic [1:0] {
    SRC_XTAL = 2'd0,
    SRC_OSC  = 2'd1,
    SRC_CORE = 2'd2
  } src_e;

  localparam logic [1:0] ADR_LOAD = 2'd0;
  localparam logic [1:0] ADR_VAL  = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;
  localparam logic [1:0] ADR_CLR  = 2'd3;

  localparam int B_UP  = 8;
  localparam int B_EN  = 7;
  localparam int B_PER = 6;

  // Power-of-two exponent for a prescale code; unknown codes divide by one.
  function automatic logic [3:0] psc_shift(input logic [3:0] code);
    case (code)
      4'h4:    return 4'd4;
      4'h8:    return 4'd8;
      4'hF:    return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [31:0] time_inc(input logic [31:0] v, input logic [7:0] hmax);
    logic [7:0] h, m, s, c;
    {h, m, s, c} = v;
    if (c < 8'd99) c = c + 8'd1;
    else begin
      c = 8'd0;
      if (s < 8'd59) s = s + 8'd1;
      else begin
        s = 8'd0;
        if (m < 8'd59) m = m + 8'd1;
        else begin
          m = 8'd0;
          if (h < hmax) h = h + 8'd1;
          else h = 8'd0;
        end
      end
    end
    return {h, m, s, c};
  endfunction

  function automatic logic [31:0] time_dec(input logic [31:0] v, input logic [7:0] hmax);
    logic [7:0] h, m, s, c;
    {h, m, s, c} = v;
    if (c != 8'd0) c = c - 8'd1;
    else begin
      c = 8'd99;
      if (s != 8'd0) s = s - 8'd1;
      else begin
        s = 8'd59;
        if (m != 8'd0) m = m - 8'd1;
        else begin
          m = 8'd59;
          if (h != 8'd0) h = h - 8'd1;
          else h = hmax;
        end
      end
    end
    return {h, m, s, c};
  endfunction
endpackage

// File: rtl/wt_sync.sv
module wt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wt_bus_regs.sv
module wt_bus_regs
  import wt_pkg::*;
(
  input  logic              bus_clk,
  input  logic              bus_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [1:0]        src_sel,
  output logic [CTRL_W-1:0] h_ctrl,
  output logic [CNT_W-1:0]  h_load,
  output logic              h_ldf,
  output logic              cfg_req,
  input  logic              cfg_ack_s,
  output logic              snap_req,
  input  logic              snap_ack_s,
  input  logic [CNT_W-1:0]  snap_data,
  output logic              clr_tgl
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q;
  logic [CNT_W-1:0]  val_sh;
  logic              pend, ld_pend;
  logic              busy;

  assign busy = (cfg_req != cfg_ack_s);

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      ctrl_q   <= '0;
      load_q   <= '0;
      val_sh   <= '1;
      pend     <= 1'b0;
      ld_pend  <= 1'b0;
      h_ctrl   <= '0;
      h_load   <= '0;
      h_ldf    <= 1'b0;
      cfg_req  <= 1'b0;
      snap_req <= 1'b0;
      clr_tgl  <= 1'b0;
      rdata    <= '0;
      src_sel  <= SRC_XTAL;
    end else begin
      // launch a pending configuration when the previous one was taken
      if (pend && !busy) begin
        h_ctrl  <= ctrl_q;
        h_load  <= load_q;
        h_ldf   <= ld_pend;
        cfg_req <= ~cfg_req;
        pend    <= 1'b0;
        ld_pend <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          ADR_CTRL: begin ctrl_q <= wdata[CTRL_W-1:0]; pend <= 1'b1; end
          ADR_LOAD: begin load_q <= wdata; pend <= 1'b1; ld_pend <= 1'b1; end
          ADR_CLR:  clr_tgl <= ~clr_tgl;
          default:  ;
        endcase
      end
      // snapshot loop: copy the stable holding word, then ask for a new one
      if (snap_ack_s == snap_req) begin
        val_sh   <= snap_data;
        snap_req <= ~snap_req;
      end
      if (rd_en) begin
        case (addr)
          ADR_LOAD: rdata <= load_q;
          ADR_VAL:  rdata <= val_sh;
          ADR_CTRL: rdata <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
          default:  rdata <= '0;
        endcase
      end
      case (ctrl_q[10:9])
        2'b10:   src_sel <= SRC_OSC;
        2'b11:   src_sel <= SRC_CORE;
        default: src_sel <= SRC_XTAL;
      endcase
    end
  end
endmodule

// File: rtl/wt_core.sv
module wt_core
  import wt_pkg::*;
#(
  parameter int PSC_W = 15
) (
  input  logic              tmr_clk,
  input  logic              tmr_rst,
  input  logic              cfg_req_s,
  input  logic [CTRL_W-1:0] h_ctrl,
  input  logic [CNT_W-1:0]  h_load,
  input  logic              h_ldf,
  output logic              cfg_ack,
  input  logic              snap_req_s,
  output logic              snap_ack,
  output logic [CNT_W-1:0]  snap_hold,
  input  logic              clr_s,
  output logic              irq,
  output logic              conv_start
);
  logic [CTRL_W-1:0] ctrl_r;
  logic [CNT_W-1:0]  load_r, cnt, nxt_free, nxt, tmax;
  logic [PSC_W-1:0]  psc;
  logic [PSC_W:0]    mask_w;
  logic [7:0]        hmax;
  logic              clr_seen;
  logic              en, up, per, is_time, tick, term, cfg_new, clr_new, evt;

  assign en      = ctrl_r[B_EN];
  assign up      = ctrl_r[B_UP];
  assign per     = ctrl_r[B_PER];
  assign is_time = ctrl_r[5];
  assign cfg_new = (cfg_req_s != cfg_ack);
  assign clr_new = (clr_s != clr_seen);

  always_comb begin
    mask_w   = ({{PSC_W{1'b0}}, 1'b1} << psc_shift(ctrl_r[3:0])) - 1'b1;
    tick     = (psc == mask_w[PSC_W-1:0]);
    hmax     = ctrl_r[4] ? 8'hFF : 8'd23;
    tmax     = {hmax, 8'd59, 8'd59, 8'd99};
    if (up) term = is_time ? (cnt == tmax) : (&cnt);
    else    term = (cnt == '0);
    if (is_time) nxt_free = up ? time_inc(cnt, hmax) : time_dec(cnt, hmax);
    else         nxt_free = up ? cnt + 1'b1 : cnt - 1'b1;
    nxt = (per && term) ? load_r : nxt_free;
    evt = !cfg_new && en && tick && term;
  end

  always_ff @(posedge tmr_clk) begin
    if (tmr_rst) begin
      ctrl_r     <= '0;
      load_r     <= '0;
      cnt        <= '1;
      psc        <= '0;
      cfg_ack    <= 1'b0;
      snap_ack   <= 1'b0;
      snap_hold  <= '1;
      clr_seen   <= 1'b0;
      irq        <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= evt;
      clr_seen   <= clr_s;
      if (cfg_new) begin
        ctrl_r  <= h_ctrl;
        load_r  <= h_load;
        cfg_ack <= cfg_req_s;
        psc     <= '0;
        if (h_ldf) cnt <= h_load;
      end else if (en) begin
        if (tick) begin
          psc <= '0;
          cnt <= nxt;
        end else begin
          psc <= psc + 1'b1;
        end
      end else begin
        psc <= '0;
      end
      if (evt)          irq <= 1'b1;
      else if (clr_new) irq <= 1'b0;
      if (snap_req_s != snap_ack) begin
        snap_hold <= cnt;
        snap_ack  <= snap_req_s;
      end
    end
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wt_pkg::*;
#(
  parameter int PSC_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic        bus_clk,
  input  logic        bus_rst,
  input  logic        tmr_clk,
  input  logic        tmr_rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [1:0]  src_sel,
  output logic        irq,
  output logic        conv_start
);
  logic [CTRL_W-1:0] h_ctrl;
  logic [CNT_W-1:0]  h_load, snap_hold;
  logic              h_ldf, cfg_req, cfg_ack, snap_req, snap_ack, clr_tgl;
  logic              cfg_req_s, snap_req_s, clr_s, cfg_ack_s, snap_ack_s;

  wt_bus_regs u_bus (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .src_sel(src_sel),
    .h_ctrl(h_ctrl), .h_load(h_load), .h_ldf(h_ldf),
    .cfg_req(cfg_req), .cfg_ack_s(cfg_ack_s),
    .snap_req(snap_req), .snap_ack_s(snap_ack_s), .snap_data(snap_hold),
    .clr_tgl(clr_tgl)
  );

  wt_sync #(.W(3), .STAGES(SYNC_STAGES)) u_to_tmr (
    .clk(tmr_clk), .rst(tmr_rst),
    .d({cfg_req, snap_req, clr_tgl}),
    .q({cfg_req_s, snap_req_s, clr_s})
  );

  wt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk(bus_clk), .rst(bus_rst),
    .d({cfg_ack, snap_ack}),
    .q({cfg_ack_s, snap_ack_s})
  );

  wt_core #(.PSC_W(PSC_W)) u_core (
    .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .cfg_req_s(cfg_req_s), .h_ctrl(h_ctrl), .h_load(h_load), .h_ldf(h_ldf),
    .cfg_ack(cfg_ack), .snap_req_s(snap_req_s), .snap_ack(snap_ack),
    .snap_hold(snap_hold), .clr_s(clr_s), .irq(irq), .conv_start(conv_start)
  );
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk (
  input logic        bus_clk,
  input logic        bus_rst,
  input logic        tmr_clk,
  input logic        tmr_rst,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic [1:0]  src_sel,
  input logic        irq,
  input logic        conv_start,
  input logic        clr_s
);
  // R11: interrupt only falls after a synchronised clear toggle
  a_r11_irq_sticky: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    $fell(irq) |-> ($past(clr_s) != $past(clr_s, 2)));

  // R4: a conversion pulse always comes with the interrupt set
  a_r4_conv_with_irq: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
    conv_start |-> irq);

  // R2: reserved control bits read as zero
  a_r2_rsvd_zero: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (rd_en && addr == 2'd2) |=> (rdata[31:11] == 21'd0));

  // R3: core-clock code reaches the source output two cycles after the write
  a_r3_src_core: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (wr_en && addr == 2'd2 && wdata[10:9] == 2'b11) |=> ##1 (src_sel == 2'd2));
endmodule

bind wake_timer wake_timer_chk u_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
  .src_sel(src_sel), .irq(irq), .conv_start(conv_start), .clr_s(clr_s)
);

// File: tb/wake_timer_bench.sv
module wake_timer_bench;
  localparam int BUS_HALF = 5;
  localparam int TMR_HALF = 3;

  logic bus_raw = 1'b0, bus_on = 1'b1, tmr_clk = 1'b0;
  logic bus_clk;
  logic bus_rst = 1'b1, tmr_rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [1:0]  src_sel;
  logic        irq, conv_start;

  int n_run = 0, n_fail = 0;
  int gap = 0, last_gap = 0, n_conv = 0;

  always #BUS_HALF bus_raw = ~bus_raw;
  always #TMR_HALF tmr_clk = ~tmr_clk;
  assign bus_clk = bus_raw & bus_on;

  wake_timer u_wake_timer (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .tmr_clk(tmr_clk), .tmr_rst(tmr_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .src_sel(src_sel), .irq(irq), .conv_start(conv_start)
  );

  always @(negedge tmr_clk) begin
    gap = gap + 1;
    if (conv_start) begin
      last_gap = gap;
      gap = 0;
      n_conv = n_conv + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [1:0] a, input logic [31:0] d);
    @(negedge bus_raw);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge bus_raw);
    wr_en = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [31:0] d);
    @(negedge bus_raw);
    rd_en = 1'b1; addr = a;
    @(negedge bus_raw);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    repeat (40) @(negedge bus_raw);
  endtask

  function automatic logic [31:0] cw(input logic [1:0] src, input logic up, input logic en,
                                     input logic per, input logic [1:0] fmt, input logic [3:0] p);
    return {21'd0, src, up, en, per, fmt, p};
  endfunction

  task automatic arm(input logic [31:0] ld, input logic [31:0] c);
    bwr(2'd2, c & ~32'h80);
    bwr(2'd0, ld);
    settle();
    bwr(2'd3, 32'd0);
    settle();
    bwr(2'd2, c);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 60000 && irq !== 1'b1; i++) @(negedge bus_raw);
  endtask

  task automatic halt(input logic [31:0] c, output logic [31:0] v);
    bwr(2'd2, c & ~32'h80);
    settle();
    brd(2'd1, v);
  endtask

  task automatic one_step(input logic [31:0] c, output logic [31:0] v);
    logic [31:0] v0, vn;
    settle();
    brd(2'd1, v0);
    vn = v0;
    for (int i = 0; i < 2000 && vn == v0; i++) brd(2'd1, vn);
    halt(c, v);
  endtask

  task automatic period(input string tag, input logic [31:0] ld, input logic [3:0] p,
                        input int exp);
    int n0;
    arm(ld, cw(2'd0, 1'b0, 1'b1, 1'b1, 2'd0, p));
    settle();
    n0 = n_conv;
    for (int i = 0; i < 190000 && n_conv < n0 + 2; i++) @(negedge tmr_clk);
    chk(tag, last_gap, exp);
    bwr(2'd2, 32'd0);
    settle();
  endtask

  initial begin
    #1900000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    repeat (6) @(negedge bus_raw);
    bus_rst = 1'b0; tmr_rst = 1'b0;
    settle();

    // R1 reset state
    brd(2'd2, v); chk("R1 ctrl", v, 32'd0);
    brd(2'd0, v); chk("R1 load", v, 32'd0);
    brd(2'd1, v); chk("R1 value", v, 32'hFFFFFFFF);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 reserved bits
    bwr(2'd2, 32'hFFFFF87F);
    brd(2'd2, v); chk("R2 rsvd", v, 32'h0000007F);

    // R3 source select codes
    for (int s = 0; s < 4; s++) begin
      bwr(2'd2, s << 9);
      repeat (3) @(negedge bus_raw);
      chk("R3 src", {30'd0, src_sel}, (s == 2) ? 32'd1 : (s == 3) ? 32'd2 : 32'd0);
    end

    // R10 load while disabled, no counting
    bwr(2'd2, 32'd0);
    bwr(2'd0, 32'd100);
    settle(); settle();
    brd(2'd1, v); chk("R10 load hold", v, 32'd100);

    // R4 binary down free-running
    c = cw(2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h4);
    arm(32'd5, c); wait_irq();
    chk("R4 irq", {31'd0, irq}, 32'd1);
    halt(c, v); chk("R4 wrap", v, 32'hFFFFFFFF);

    // R11 sticky then cleared
    settle();
    chk("R11 held", {31'd0, irq}, 32'd1);
    bwr(2'd3, 32'h5A); settle();
    chk("R11 clear", {31'd0, irq}, 32'd0);

    // R5 periodic reload value
    c = cw(2'd0, 1'b0, 1'b1, 1'b1, 2'b00, 4'h8);
    arm(32'd2, c); wait_irq();
    halt(c, v); chk("R5 reload", v, 32'd2);

    // R6 prescaler periods (R5 spacing)
    period("R6 div1", 32'd5, 4'h0, 6);
    period("R6 div16", 32'd3, 4'h4, 64);
    period("R6 div256", 32'd0, 4'h8, 256);
    period("R6 other code", 32'd5, 4'h1, 6);
    period("R6 div32768", 32'd0, 4'hF, 32768);

    // R7 binary up
    c = cw(2'd0, 1'b1, 1'b1, 1'b0, 2'b00, 4'h8);
    arm(32'hFFFFFFFE, c); wait_irq();
    halt(c, v); chk("R7 up wrap", v, 32'd0);
    c = cw(2'd0, 1'b1, 1'b1, 1'b1, 2'b00, 4'h8);
    arm(32'hFFFFFFFE, c); wait_irq();
    halt(c, v); chk("R7 up periodic", v, 32'hFFFFFFFE);

    // R8 time up
    c = cw(2'd0, 1'b1, 1'b1, 1'b0, 2'b10, 4'h8);
    arm(32'h173B3B62, c); wait_irq();
    halt(c, v); chk("R8 23h wrap", v, 32'd0);
    c = cw(2'd0, 1'b1, 1'b1, 1'b0, 2'b11, 4'h8);
    arm(32'h173B3B63, c); one_step(c, v);
    chk("R8 255h carry", v, 32'h18000000);
    chk("R8 no event", {31'd0, irq}, 32'd0);
    arm(32'hFF3B3B63, c); wait_irq();
    halt(c, v); chk("R8 255h wrap", v, 32'd0);

    // R9 time down
    c = cw(2'd0, 1'b0, 1'b1, 1'b0, 2'b10, 4'h8);
    arm(32'h01000000, c); one_step(c, v);
    chk("R9 borrow", v, 32'h003B3B63);
    arm(32'h00000000, c); wait_irq();
    halt(c, v); chk("R9 23h wrap", v, 32'h173B3B63);
    c = cw(2'd0, 1'b0, 1'b1, 1'b0, 2'b11, 4'h8);
    arm(32'h00000000, c); wait_irq();
    halt(c, v); chk("R9 255h wrap", v, 32'hFF3B3B63);

    // R12 interrupt with bus clock stopped
    c = cw(2'd0, 1'b0, 1'b1, 1'b0, 2'b00, 4'h4);
    arm(32'd40, c);
    settle();
    @(negedge bus_raw); bus_on = 1'b0;
    for (int i = 0; i < 5000 && irq !== 1'b1; i++) @(negedge tmr_clk);
    chk("R12 irq gated", {31'd0, irq}, 32'd1);
    @(negedge bus_raw); bus_on = 1'b1;
    halt(c, v); chk("R12 wrapped", v, 32'hFFFFFFFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule